// File: doc/BRIEF.md
# DSP Status Mode Byte Controller

This block holds the upper byte of a DSP status word. That byte carries the mode controls: the loop-active flag, the double-precision multiply enable, the single-step trace enable, a reserved position, the two-bit scaling selector and two general mode bits. The block updates the byte on processor events and exports each control to the rest of the core. The events are reset, software writes, hardware-loop entry and exit, long-interrupt entry, return from interrupt, and instruction start and completion.

Each field follows its own rule on each event. Interrupt entry saves the whole status word to an external system stack and then clears the loop, trace and scaling fields. Return from interrupt restores the entire byte from the stack. Loop entry saves the word and sets the loop flag. Loop exit pulls a word and restores only the loop flag, which lets loops nest. A trace request is raised after any instruction that began while trace was enabled.

The stack port is a pair of plain strobes with no back-pressure. When `push_o` is high, the stack must accept `push_data_o` in that cycle. When `pop_o` is high, `pop_data_i` must already present the top entry, and the block consumes it at that clock edge. Because every strobe is accepted in its own cycle, no valid/ready handshake is needed.

Top module: `smr_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, `mode_o` is 0x00, `trace_req_o` is 0 and no stack strobe is active until an event occurs.
- R2: Bit 4 of `mode_o` (status bit 12) always reads 0. A software write or a popped word that carries a 1 there does not set it.
- R3: A software write (`sw_we_i`) loads `sw_wdata_i` into the byte at the next clock edge. The byte layout is bit 7 = loop flag, bit 6 = double-precision, bit 5 = trace, bits 3:2 = scaling, bits 1:0 = general mode bits.
- R4: When `instr_start_i` is high while the trace bit is 1, `trace_req_o` is high for one cycle, in the cycle after the matching `instr_done_i`. If the trace bit was 0 at start, no request is raised. The trace bit is sampled at start, so a later change does not cancel or create a request.
- R5: On `irq_entry_i`, `push_o` is high in the same cycle with `push_data_o` = {mode byte, `cc_byte_i`}. At the next edge the loop, trace and scaling fields clear, and the double-precision and general bits are kept.
- R6: On `rti_i`, `pop_o` is high in the same cycle, and at the next edge the byte becomes `pop_data_i[15:8]`, with bit 4 forced to 0.
- R7: On `loop_start_i`, `push_o` is high with the current status word, and at the next edge the loop flag is 1 with the other bits unchanged.
- R8: On `loop_end_i`, `pop_o` is high, and at the next edge only the loop flag is replaced, by `pop_data_i[15]`.
- R9: When several events coincide, only the highest-priority one acts, including its stack strobe. The order from highest is interrupt entry, return, loop end, loop start, software write. `push_o` and `pop_o` are never high together.
- R10: The scaling field drives `scale_o` and `round_pos_o`. 00 gives no scaling with rounding at RND_BASE. 01 gives scale-down with rounding at RND_BASE+1. 10 gives scale-up with rounding at RND_BASE-1. 11 is treated as 00. `scale_o` never reads 11.
- R11: `lf_o`, `dm_o` and `trace_o` equal bits 7, 6 and 5 of `mode_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Software write strobe for the mode byte |
| sw_wdata_i | input | 8 | Software write data |
| loop_start_i | input | 1 | Hardware loop entry strobe |
| loop_end_i | input | 1 | Hardware loop termination strobe |
| irq_entry_i | input | 1 | Long-interrupt entry strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| instr_start_i | input | 1 | Instruction begins this cycle |
| instr_done_i | input | 1 | Instruction completes this cycle |
| cc_byte_i | input | 8 | Lower status byte, supplied by the condition-code logic for pushes |
| push_o | output | 1 | Stack push strobe |
| push_data_o | output | 16 | Word to push |
| pop_o | output | 1 | Stack pop strobe |
| pop_data_i | input | 16 | Top-of-stack word |
| mode_o | output | 8 | Current mode byte (status bits 15:8) |
| scale_o | output | 2 | Effective scaling: 0 none, 1 down, 2 up |
| round_pos_o | output | $clog2(ACC_W) | Accumulator bit index for MAC rounding |
| dm_o | output | 1 | Double-precision multiply enable |
| lf_o | output | 1 | Loop flag |
| trace_o | output | 1 | Trace enable |
| trace_req_o | output | 1 | One-cycle trace exception request |

## Verification
The collisions that matter most are between stack events and between a trace arm and an instruction completion. The bench raises interrupt entry, return, loop end, loop start and software write in the same cycle in several combinations. For each one it checks that a single strobe appears and that only the winner's update lands. It also overlaps `instr_start_i` with `instr_done_i`, and overlaps a trace-clearing write with an instruction start, to confirm that the arming value is the one sampled at start. Every cycle, all outputs are compared against a behavioural model that keeps its own stack queue.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int MB_W  = 8;
  localparam int B_LF  = 7;
  localparam int B_DM  = 6;
  localparam int B_TR  = 5;
  localparam int B_RSV = 4;
  localparam int B_SC  = 2;   // scaling field occupies B_SC+1:B_SC

  localparam logic [MB_W-1:0] RSV_MASK = ~(MB_W'(1) << B_RSV);
  localparam logic [MB_W-1:0] IRQ_KEEP =
    ~((MB_W'(1) << B_LF) | (MB_W'(1) << B_TR) | (MB_W'(3) << B_SC));

  typedef enum logic [2:0] {
    EV_NONE, EV_IRQ, EV_RTI, EV_LEND, EV_LSTART, EV_WRITE
  } ev_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_DOWN = 2'b01,
    SC_UP   = 2'b10
  } scale_e;
endpackage

// File: rtl/smr_event_arb.sv
module smr_event_arb
  import smr_pkg::*;
#(
  parameter int N_EV = 5
) (
  input  logic [N_EV-1:0] req_i,   // index 0 is highest priority
  output ev_e             ev_o
);
  localparam int IW = (N_EV > 1) ? $clog2(N_EV) : 1;

  logic [IW-1:0] win_idx;
  logic          any;

  always_comb begin
    win_idx = '0;
    any     = 1'b0;
    for (int i = N_EV - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        win_idx = IW'(i);
        any     = 1'b1;
      end
    end
  end

  always_comb begin
    ev_o = EV_NONE;
    if (any) begin
      case (win_idx)
        IW'(0):  ev_o = EV_IRQ;
        IW'(1):  ev_o = EV_RTI;
        IW'(2):  ev_o = EV_LEND;
        IW'(3):  ev_o = EV_LSTART;
        default: ev_o = EV_WRITE;
      endcase
    end
  end
endmodule

// File: rtl/smr_trace_unit.sv
module smr_trace_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_bit_i,
  input  logic start_i,
  input  logic done_i,
  output logic req_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      req_o <= done_i & armed_q;
      if (start_i)
        armed_q <= trace_bit_i;
      else if (done_i)
        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smr_scale_decode.sv
module smr_scale_decode
  import smr_pkg::*;
#(
  parameter int ACC_W    = 56,
  parameter int RND_BASE = 23,
  parameter int PW       = $clog2(ACC_W)
) (
  input  logic [1:0]    field_i,
  output logic [1:0]    scale_o,
  output logic [PW-1:0] round_pos_o
);
  localparam logic [PW-1:0] POS_NONE = PW'(RND_BASE);
  localparam logic [PW-1:0] POS_DOWN = PW'(RND_BASE + 1);
  localparam logic [PW-1:0] POS_UP   = PW'(RND_BASE - 1);

  scale_e sc;

  always_comb begin
    case (field_i)
      2'b01:   sc = SC_DOWN;
      2'b10:   sc = SC_UP;
      default: sc = SC_NONE;
    endcase
  end

  always_comb begin
    case (sc)
      SC_DOWN: round_pos_o = POS_DOWN;
      SC_UP:   round_pos_o = POS_UP;
      default: round_pos_o = POS_NONE;
    endcase
  end

  assign scale_o = sc;
endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl
  import smr_pkg::*;
#(
  parameter int SR_W     = 16,
  parameter int ACC_W    = 56,
  parameter int RND_BASE = 23,
  localparam int PW      = $clog2(ACC_W),
  localparam int LO_W    = SR_W - MB_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we_i,
  input  logic [MB_W-1:0] sw_wdata_i,
  input  logic            loop_start_i,
  input  logic            loop_end_i,
  input  logic            irq_entry_i,
  input  logic            rti_i,
  input  logic            instr_start_i,
  input  logic            instr_done_i,
  input  logic [LO_W-1:0] cc_byte_i,
  output logic            push_o,
  output logic [SR_W-1:0] push_data_o,
  output logic            pop_o,
  input  logic [SR_W-1:0] pop_data_i,
  output logic [MB_W-1:0] mode_o,
  output logic [1:0]      scale_o,
  output logic [PW-1:0]   round_pos_o,
  output logic            dm_o,
  output logic            lf_o,
  output logic            trace_o,
  output logic            trace_req_o
);
  logic [MB_W-1:0] mode_q, mode_d;
  logic [MB_W-1:0] popped;
  ev_e             ev;

  smr_event_arb #(.N_EV(5)) u_arb (
    .req_i ({sw_we_i, loop_start_i, loop_end_i, rti_i, irq_entry_i}),
    .ev_o  (ev)
  );

  assign popped = pop_data_i[SR_W-1 -: MB_W];

  always_comb begin
    mode_d = mode_q;
    unique case (ev)
      EV_IRQ:    mode_d = mode_q & IRQ_KEEP;
      EV_RTI:    mode_d = popped & RSV_MASK;
      EV_LEND:   mode_d[B_LF] = popped[B_LF];
      EV_LSTART: mode_d[B_LF] = 1'b1;
      EV_WRITE:  mode_d = sw_wdata_i & RSV_MASK;
      default:   mode_d = mode_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign push_o      = (ev == EV_IRQ) || (ev == EV_LSTART);
  assign pop_o       = (ev == EV_RTI) || (ev == EV_LEND);
  assign push_data_o = {mode_q, cc_byte_i};

  smr_trace_unit u_trace (
    .clk         (clk),
    .rst_n       (rst_n),
    .trace_bit_i (mode_q[B_TR]),
    .start_i     (instr_start_i),
    .done_i      (instr_done_i),
    .req_o       (trace_req_o)
  );

  smr_scale_decode #(.ACC_W(ACC_W), .RND_BASE(RND_BASE), .PW(PW)) u_scale (
    .field_i     (mode_q[B_SC+1:B_SC]),
    .scale_o     (scale_o),
    .round_pos_o (round_pos_o)
  );

  assign mode_o  = mode_q;
  assign lf_o    = mode_q[B_LF];
  assign dm_o    = mode_q[B_DM];
  assign trace_o = mode_q[B_TR];
endmodule

// File: rtl/smr_ctrl_chk.sv
module smr_ctrl_chk #(
  parameter int SR_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_entry_i,
  input logic            rti_i,
  input logic            loop_end_i,
  input logic            loop_start_i,
  input logic            instr_done_i,
  input logic            push_o,
  input logic            pop_o,
  input logic [SR_W-1:0] push_data_o,
  input logic [SR_W-1:0] pop_data_i,
  input logic [7:0]      mode_o,
  input logic [1:0]      scale_o,
  input logic            lf_o,
  input logic            trace_o,
  input logic            trace_req_o
);
  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[4] == 1'b0);

  a_r5_irq_push: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry_i |-> push_o && push_data_o[SR_W-1 -: 8] == mode_o);

  a_r5_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry_i |=> !lf_o && !trace_o && mode_o[3:2] == 2'b00);

  a_r7_loop_set: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start_i && !irq_entry_i && !rti_i && !loop_end_i) |=> lf_o);

  a_r8_lf_only: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end_i && !irq_entry_i && !rti_i) |=>
      (lf_o == $past(pop_data_i[SR_W-1])) && (mode_o[6:0] == $past(mode_o[6:0])));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && pop_o));

  a_r4_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req_o |-> $past(instr_done_i));

  a_r10_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    scale_o != 2'b11);
endmodule

bind smr_ctrl smr_ctrl_chk #(.SR_W(SR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_entry_i  (irq_entry_i),
  .rti_i        (rti_i),
  .loop_end_i   (loop_end_i),
  .loop_start_i (loop_start_i),
  .instr_done_i (instr_done_i),
  .push_o       (push_o),
  .pop_o        (pop_o),
  .push_data_o  (push_data_o),
  .pop_data_i   (pop_data_i),
  .mode_o       (mode_o),
  .scale_o      (scale_o),
  .lf_o         (lf_o),
  .trace_o      (trace_o),
  .trace_req_o  (trace_req_o)
);

// File: tb/test_smr_ctrl.sv
module test_smr_ctrl;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        sw_we, loop_start, loop_end, irq, rti, istart, idone;
  logic [7:0]  wdata, cc;
  logic        push, pop, dm, lf, tr, treq;
  logic [15:0] push_data, pop_data;
  logic [7:0]  mode;
  logic [1:0]  scale;
  logic [5:0]  rpos;

  smr_ctrl i_smr_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we), .sw_wdata_i(wdata),
    .loop_start_i(loop_start), .loop_end_i(loop_end), .irq_entry_i(irq),
    .rti_i(rti), .instr_start_i(istart), .instr_done_i(idone),
    .cc_byte_i(cc), .push_o(push), .push_data_o(push_data), .pop_o(pop),
    .pop_data_i(pop_data), .mode_o(mode), .scale_o(scale),
    .round_pos_o(rpos), .dm_o(dm), .lf_o(lf), .trace_o(tr),
    .trace_req_o(treq)
  );

  int          n_run = 0, n_fail = 0;
  logic [15:0] stk[$];
  logic [7:0]  m_ref = 8'h00;
  bit          armed_ref = 0, req_ref = 0;
  string       tag = "R1";

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_regs();
    logic [1:0] s;
    s = (m_ref[3:2] == 2'b11) ? 2'b00 : m_ref[3:2];
    chk("mode", mode, m_ref);
    chk("scale", scale, s);                                   // R10
    chk("round", rpos, (s == 2'd1) ? 24 : (s == 2'd2) ? 22 : 23);
    chk("flags", {lf, dm, tr}, {m_ref[7], m_ref[6], m_ref[5]}); // R11
    chk("trace_req", treq, req_ref);
  endtask

  task automatic tick();
    bit          e_push, e_pop;
    logic [7:0]  top, nm;
    #1;
    top    = pop_data[15:8];
    e_push = irq || (!rti && !loop_end && loop_start);
    e_pop  = !irq && (rti || loop_end);
    chk("push", push, e_push);
    chk("pop", pop, e_pop);
    if (e_push) chk("push_data", push_data, {m_ref, cc});
    if (irq)             nm = m_ref & 8'b0101_0011;
    else if (rti)        nm = top & 8'hEF;
    else if (loop_end)   nm = {top[7], m_ref[6:0]};
    else if (loop_start) nm = m_ref | 8'h80;
    else if (sw_we)      nm = wdata & 8'hEF;
    else                 nm = m_ref;
    @(posedge clk);
    if (e_push) stk.push_back({m_ref, cc});
    if (e_pop && stk.size() > 0) void'(stk.pop_back());
    req_ref = idone && armed_ref;
    if (istart)     armed_ref = m_ref[5];
    else if (idone) armed_ref = 0;
    m_ref = nm;
    #1;
    check_regs();
    pop_data = (stk.size() > 0) ? stk[$] : 16'h0000;
  endtask

  task automatic clr();
    {sw_we, loop_start, loop_end, irq, rti, istart, idone} = '0;
  endtask

  task automatic wr(logic [7:0] v);
    sw_we = 1; wdata = v; tick(); clr();
  endtask

  task automatic do_reset();
    #1 rst_n = 0;
    stk.delete(); m_ref = 0; armed_ref = 0; req_ref = 0;
    pop_data = 16'h0000;
    @(posedge clk); #1;
    tag = "R1";
    check_regs();
    chk("push_rst", push, 0);
    chk("pop_rst", pop, 0);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; clr(); wdata = 0; cc = 8'h5A; pop_data = 0;
    repeat (3) @(posedge clk);
    do_reset();
    tick();

    tag = "R3"; wr(8'h43); wr(8'h00);
    tag = "R2"; wr(8'hFF); wr(8'h10);
    tag = "R10"; wr(8'h04); wr(8'h08); wr(8'h0C); wr(8'h00);
    tag = "R11"; wr(8'hE0); wr(8'h00);

    // R4: trace armed at start, request after done
    tag = "R4"; wr(8'h20);
    istart = 1; tick(); clr();
    tick();
    idone = 1; istart = 1; tick(); clr();
    idone = 1; tick(); clr();
    tick();
    istart = 1; sw_we = 1; wdata = 8'h00; tick(); clr();  // old T=1 arms
    idone = 1; tick(); clr();
    tick();
    istart = 1; tick(); clr();
    idone = 1; tick(); clr();
    tick();

    // R7/R8: nested loops
    tag = "R7"; cc = 8'hA5;
    loop_start = 1; tick(); clr();
    loop_start = 1; tick(); clr();
    wr(8'hC4);
    tag = "R8";
    loop_end = 1; tick(); clr();
    loop_end = 1; tick(); clr();

    // R5/R6: interrupt entry and return
    tag = "R5"; wr(8'hEF); cc = 8'h3C;
    irq = 1; tick(); clr();
    wr(8'h08);
    tag = "R6"; rti = 1; tick(); clr();
    stk.push_back(16'hFF00); pop_data = 16'hFF00;
    tag = "R2"; rti = 1; tick(); clr();

    // R9: collisions
    tag = "R9"; wr(8'h00);
    irq = 1; rti = 1; loop_end = 1; loop_start = 1; sw_we = 1; wdata = 8'h99;
    tick(); clr();
    stk.push_back(16'h8123); pop_data = 16'h8123;
    rti = 1; loop_end = 1; loop_start = 1; tick(); clr();
    stk.push_back(16'h0000); pop_data = 16'h0000;
    loop_end = 1; loop_start = 1; sw_we = 1; wdata = 8'h44; tick(); clr();
    loop_start = 1; sw_we = 1; wdata = 8'h08; tick(); clr();
    wr(8'h24);

    do_reset();
    tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule